// File: doc/BRIEF.md
# Capacitive-Sense Acquisition Sequencer

This block runs a short program of acquisition commands each time a record trigger arrives. It starts at address zero of an external command store and presents one command at a time. While a command is active, its bits drive the charge-control lines of the sensing capacitor array (discharge to ground, charge to supply, share charge with the sense pin). They also drive a 2-bit drive mode for the sense pin and for each of three transmit/guard pin groups. A command may fire a convert-start strobe and a request to run one of two math sequences.

A command can hold the sequencer before it moves on. The hold is either a settle delay or a wait for the converter to report completion. The settle delay comes from one of four programmable list timers or from the sample-time value. The program ends after a command flagged as the last one completes. While the program runs, the busy output is high and further triggers have no effect. When idle, every output returns to its inactive value, and every pin group goes back to normal port control.

Top module: `csense_seq`

## Requirements
- R1: When idle, a high trigger in a clock cycle makes busy high and the command address 0 from the next cycle. The command word read at the current address then drives the outputs.
- R2: When a command with the last bit completes its hold, busy is low from the next cycle. While idle, discharge, charge, share, convert-start and math request are 0, and all pin-mode outputs are 0.
- R3: A trigger that arrives while busy is high is ignored, including in the final cycle of the last command. The address is not reset and busy is not extended.
- R4: The command word layout is as follows: bits [3:0] hold select, bit 4 discharge, bit 5 charge, bit 6 share, bit 7 convert, bit 8 math request, bit 9 second math sequence, bit 10 last, [12:11] sense pin mode, [14:13] group A mode, [16:15] group B mode, [18:17] group C mode. While busy, discharge, charge, share and the four pin modes follow the active command for every cycle it is held. tx_mode_o carries {C,B,A}. Pin modes: 0 port control, 1 drive low, 2 drive high, 3 tri-state.
- R5: Hold select 0, 1, 2 and 9 to 15 means no hold. The command is active for exactly one cycle and the address then increments by one.
- R6: Hold select 5, 6, 7 and 8 picks list timer 0, 1, 2 and 3. Timer k occupies list_tmr_i[8k+7:8k]. With a timer value N, the command stays active for N+2 cycles.
- R7: Hold select 3 uses the sample-time input as the timer value, with the same N+2 cycle rule.
- R8: When the convert bit is set, convert-start is high only in the first cycle of the command. With hold select 4, the command stays active until a cycle after its first in which conversion-done is high, and the sequencer advances after that cycle. Conversion-done in the first cycle is ignored.
- R9: When the math-request bit is set, math request is high only in the first cycle of the command. In that cycle, math select equals the second-sequence bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Record trigger |
| cmd_addr_o | output | 4 | Command store read address |
| cmd_word_i | input | 19 | Command word at cmd_addr_o (same-cycle read) |
| list_tmr_i | input | 32 | Four 8-bit list timer values, timer 0 in the low byte |
| samp_time_i | input | 5 | Sample-time value used as a timer |
| conv_done_i | input | 1 | Conversion complete |
| busy_o | output | 1 | Program running |
| drain_o | output | 1 | Discharge capacitor array to ground |
| fill_o | output | 1 | Charge capacitor array to supply |
| share_o | output | 1 | Connect capacitor array to the sense pin |
| conv_start_o | output | 1 | Convert-start strobe |
| math_req_o | output | 1 | Math sequence request strobe |
| math_sel_o | output | 1 | 0 first, 1 second math sequence |
| sense_mode_o | output | 2 | Sense pin drive mode |
| tx_mode_o | output | 6 | Transmit group drive modes {C,B,A} |

## Verification
Two functions can fall in the same cycle. The first is a conversion-done pulse that lands in the first cycle of a conversion-wait command, the same cycle that raises convert-start. The bench drives done there and confirms that the address stays put, then that the command advances only on a later pulse. The second is a trigger that lands in the final cycle of the last command, where the sequence ends. The bench raises the trigger exactly there and confirms that busy still falls and no new run starts. A trigger mid-run is also checked to leave the current address unchanged.

// File: rtl/csense_seq_pkg.sv
// Shared types for the acquisition sequencer.
// Assumes a command word is the packed cmd_t below, last field in the LSBs.
package csense_seq_pkg;
    localparam int N_TMR = 4;
    localparam int PIN_W = 2;
    localparam int N_TX  = 3;

    localparam logic [3:0] SEL_SAMP  = 4'd3;
    localparam logic [3:0] SEL_CONV  = 4'd4;
    localparam logic [3:0] SEL_LT_LO = 4'd5;
    localparam logic [3:0] SEL_LT_HI = 4'd8;

    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_TIMER = 2'd1,
        HOLD_CONV  = 2'd2
    } hold_kind_e;

    typedef struct packed {
        logic [N_TX-1:0][PIN_W-1:0] tx;
        logic [PIN_W-1:0]           sense;
        logic                       last;
        logic                       math_alt;
        logic                       call_math;
        logic                       conv_go;
        logic                       share;
        logic                       fill;
        logic                       drain;
        logic [3:0]                 hold;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);
endpackage

// File: rtl/csense_cmd_decode.sv
// Command decoder: splits the word into fields and turns the hold select
// into a hold kind plus the value to load into the hold counter.
// Assumes SAMP_W <= TMR_W.
module csense_cmd_decode
    import csense_seq_pkg::*;
#(
    parameter int TMR_W  = 8,
    parameter int SAMP_W = 5
) (
    input  logic [CMD_W-1:0]       word_i,
    input  logic [N_TMR*TMR_W-1:0] list_tmr_i,
    input  logic [SAMP_W-1:0]      samp_time_i,
    output cmd_t                   cmd_o,
    output hold_kind_e             kind_o,
    output logic [TMR_W-1:0]       load_o
);
    logic [TMR_W-1:0] tmr [N_TMR];
    logic [1:0]       tmr_idx;

    // Unpack the flat list-timer bus, one slice per timer.
    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        assign tmr[g] = list_tmr_i[g*TMR_W +: TMR_W];
    end

    assign cmd_o   = cmd_t'(word_i);
    assign tmr_idx = cmd_o.hold[1:0] - 2'd1;

    // Map the hold select onto a hold kind and its counter load value.
    always_comb begin
        kind_o = HOLD_NONE;
        load_o = '0;
        if (cmd_o.hold == SEL_SAMP) begin
            kind_o = HOLD_TIMER;
            load_o = TMR_W'(samp_time_i);
        end else if (cmd_o.hold == SEL_CONV) begin
            kind_o = HOLD_CONV;
        end else if (cmd_o.hold >= SEL_LT_LO && cmd_o.hold <= SEL_LT_HI) begin
            kind_o = HOLD_TIMER;
            load_o = tmr[tmr_idx];
        end
    end
endmodule

// File: rtl/csense_hold_timer.sv
// Hold unit: loads its counter on the first cycle of a command and counts
// down once per clock. It raises release_o when the active command may end.
// Assumes fresh_i is high exactly in the first cycle of each command.
module csense_hold_timer
    import csense_seq_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             fresh_i,
    input  hold_kind_e       kind_i,
    input  logic [TMR_W-1:0] load_i,
    input  logic             conv_done_i,
    output logic             release_o
);
    logic [TMR_W-1:0] cnt;

    // Load on command entry, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (fresh_i) begin
            cnt <= load_i;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Decide whether the active command is allowed to complete this cycle.
    always_comb begin
        unique case (kind_i)
            HOLD_TIMER: release_o = !fresh_i && (cnt == '0);
            HOLD_CONV:  release_o = !fresh_i && conv_done_i;
            default:    release_o = 1'b1;
        endcase
    end

    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !fresh_i && kind_i == HOLD_TIMER && cnt != '0)
        |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/csense_seq.sv
// Acquisition command sequencer top. Starts at address 0 on a trigger,
// holds each command per its hold select, and stops after a last-flagged command.
// Assumes the command store returns the word for cmd_addr_o in the same cycle.
module csense_seq
    import csense_seq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int TMR_W  = 8,
    parameter int SAMP_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trig_i,
    output logic [ADDR_W-1:0]       cmd_addr_o,
    input  logic [CMD_W-1:0]        cmd_word_i,
    input  logic [N_TMR*TMR_W-1:0]  list_tmr_i,
    input  logic [SAMP_W-1:0]       samp_time_i,
    input  logic                    conv_done_i,
    output logic                    busy_o,
    output logic                    drain_o,
    output logic                    fill_o,
    output logic                    share_o,
    output logic                    conv_start_o,
    output logic                    math_req_o,
    output logic                    math_sel_o,
    output logic [PIN_W-1:0]        sense_mode_o,
    output logic [N_TX*PIN_W-1:0]   tx_mode_o
);
    cmd_t             cmd;
    hold_kind_e       kind;
    logic [TMR_W-1:0] load_val;
    logic             release_cmd;
    logic             fresh;

    csense_cmd_decode #(.TMR_W(TMR_W), .SAMP_W(SAMP_W)) u_decode (
        .word_i      (cmd_word_i),
        .list_tmr_i  (list_tmr_i),
        .samp_time_i (samp_time_i),
        .cmd_o       (cmd),
        .kind_o      (kind),
        .load_o      (load_val)
    );

    csense_hold_timer #(.TMR_W(TMR_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (busy_o),
        .fresh_i     (fresh),
        .kind_i      (kind),
        .load_i      (load_val),
        .conv_done_i (conv_done_i),
        .release_o   (release_cmd)
    );

    // Run control: start on trigger, step on release, stop after the last command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o     <= 1'b0;
            cmd_addr_o <= '0;
            fresh      <= 1'b0;
        end else if (!busy_o) begin
            if (trig_i) begin
                busy_o     <= 1'b1;
                cmd_addr_o <= '0;
                fresh      <= 1'b1;
            end
        end else if (release_cmd) begin
            if (cmd.last) begin
                busy_o <= 1'b0;
                fresh  <= 1'b0;
            end else begin
                cmd_addr_o <= cmd_addr_o + 1'b1;
                fresh      <= 1'b1;
            end
        end else begin
            fresh <= 1'b0;
        end
    end

    // Drive the front-end controls from the active command, inactive when idle.
    always_comb begin
        drain_o      = busy_o && cmd.drain;
        fill_o       = busy_o && cmd.fill;
        share_o      = busy_o && cmd.share;
        conv_start_o = busy_o && fresh && cmd.conv_go;
        math_req_o   = busy_o && fresh && cmd.call_math;
        math_sel_o   = busy_o && fresh && cmd.call_math && cmd.math_alt;
        sense_mode_o = busy_o ? cmd.sense : '0;
        tx_mode_o    = busy_o ? cmd.tx : '0;
    end

    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && trig_i) |=> (busy_o && cmd_addr_o == '0));

    p_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && release_cmd && cmd.last) |=> !busy_o);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(drain_o || fill_o || share_o || conv_start_o || math_req_o)
                    && sense_mode_o == '0 && tx_mode_o == '0);

    p_ignore_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && trig_i && !release_cmd) |=> (busy_o && $stable(cmd_addr_o)));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && release_cmd && !cmd.last) |=> (cmd_addr_o == $past(cmd_addr_o) + 1'b1));

    p_conv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && kind == HOLD_CONV && (fresh || !conv_done_i))
        |=> (busy_o && $stable(cmd_addr_o)));

    p_math_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (math_req_o && !release_cmd) |=> !math_req_o);
endmodule

// File: tb/csense_seq_test.sv
// Directed bench for the acquisition sequencer: one task per scenario.
module csense_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic        conv_done = 1'b0;
    logic [3:0]  addr;
    logic [18:0] word;
    logic [31:0] tmrs = '0;
    logic [4:0]  samp = '0;
    logic        busy, drain, fill, share, conv_start, math_req, math_sel;
    logic [1:0]  sense_mode;
    logic [5:0]  tx_mode;
    logic [18:0] mem [16];

    int checks = 0;
    int fails  = 0;

    assign word = mem[addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    csense_seq uut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .cmd_addr_o(addr),
        .cmd_word_i(word), .list_tmr_i(tmrs), .samp_time_i(samp),
        .conv_done_i(conv_done), .busy_o(busy), .drain_o(drain), .fill_o(fill),
        .share_o(share), .conv_start_o(conv_start), .math_req_o(math_req),
        .math_sel_o(math_sel), .sense_mode_o(sense_mode), .tx_mode_o(tx_mode)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Build a word in the R4 layout.
    function automatic logic [18:0] mk(logic [3:0] hold, logic dr, logic fi, logic sh,
                                       logic cv, logic mr, logic m2, logic lst,
                                       logic [1:0] s, logic [1:0] a, logic [1:0] b,
                                       logic [1:0] c);
        return {c, b, a, s, lst, m2, mr, cv, sh, fi, dr, hold};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 16; i++) mem[i] = '0;
    endtask

    task automatic fire();
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic measure(int idx, output int n);
        n = 0;
        while (busy && addr == 4'(idx) && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_outs(string req, logic d, logic f, logic s,
                              logic [1:0] sm, logic [5:0] tx);
        check(req, {29'd0, drain, fill, share}, {29'd0, d, f, s});
        check(req, {30'd0, sense_mode}, {30'd0, sm});
        check(req, {26'd0, tx_mode}, {26'd0, tx});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 reset busy", {31'd0, busy}, 32'd0);
        check("R1 reset addr", {28'd0, addr}, 32'd0);
        check_outs("R2 reset outputs", 1'b0, 1'b0, 1'b0, 2'd0, 6'd0);
        check("R2 reset strobes", {30'd0, conv_start, math_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_patterns();
        clear_mem();
        mem[0] = mk(4'd0, 1, 0, 0, 0, 0, 0, 0, 2'd1, 2'd2, 2'd3, 2'd0);
        mem[1] = mk(4'd9, 0, 1, 0, 0, 0, 0, 0, 2'd2, 2'd1, 2'd0, 2'd3);
        mem[2] = mk(4'd0, 0, 0, 1, 0, 0, 0, 1, 2'd3, 2'd3, 2'd1, 2'd2);
        fire();
        check("R1 busy after trigger", {31'd0, busy}, 32'd1);
        check("R1 start address", {28'd0, addr}, 32'd0);
        check_outs("R4 cmd0", 1, 0, 0, 2'd1, {2'd0, 2'd3, 2'd2});
        @(negedge clk);
        check("R5 hold 0 one cycle", {28'd0, addr}, 32'd1);
        check_outs("R4 cmd1", 0, 1, 0, 2'd2, {2'd3, 2'd0, 2'd1});
        @(negedge clk);
        check("R5 hold 9 one cycle", {28'd0, addr}, 32'd2);
        check_outs("R4 cmd2", 0, 0, 1, 2'd3, {2'd2, 2'd1, 2'd3});
        @(negedge clk);
        check("R2 busy after last", {31'd0, busy}, 32'd0);
        check_outs("R2 idle outputs", 0, 0, 0, 2'd0, 6'd0);
    endtask

    task automatic t_list_timers();
        int n;
        clear_mem();
        tmrs = {8'd1, 8'd6, 8'd3, 8'd0};
        mem[0] = mk(4'd6, 0, 0, 1, 0, 0, 0, 0, 2'd3, 2'd0, 2'd0, 2'd0);
        mem[1] = mk(4'd8, 0, 0, 1, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[2] = mk(4'd5, 0, 0, 1, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[3] = mk(4'd7, 0, 0, 1, 0, 0, 0, 1, 2'd0, 2'd0, 2'd0, 2'd0);
        fire();
        check("R4 share held", {31'd0, share}, 32'd1);
        measure(0, n); check("R6 timer1=3 length", n, 32'd5);
        measure(1, n); check("R6 timer3=1 length", n, 32'd3);
        measure(2, n); check("R6 timer0=0 length", n, 32'd2);
        measure(3, n); check("R6 timer2=6 length", n, 32'd8);
        check("R2 done after timers", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_samp_time();
        int n;
        clear_mem();
        samp = 5'd2;
        mem[0] = mk(4'd3,  1, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[1] = mk(4'd0,  0, 1, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[2] = mk(4'd15, 0, 1, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[3] = mk(4'd2,  0, 0, 0, 0, 0, 0, 1, 2'd0, 2'd0, 2'd0, 2'd0);
        fire();
        measure(0, n); check("R7 sample time 2 length", n, 32'd4);
        measure(1, n); check("R5 hold 0 length", n, 32'd1);
        measure(2, n); check("R5 hold 15 length", n, 32'd1);
        measure(3, n); check("R5 hold 2 length", n, 32'd1);
        check("R2 done after sample run", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_conversion();
        clear_mem();
        mem[0] = mk(4'd4, 0, 1, 0, 1, 0, 0, 0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[1] = mk(4'd0, 0, 0, 0, 1, 0, 0, 1, 2'd0, 2'd0, 2'd0, 2'd0);
        fire();
        check("R8 convert strobe first cycle", {31'd0, conv_start}, 32'd1);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        check("R8 done in first cycle ignored", {28'd0, addr}, 32'd0);
        check("R8 strobe single cycle", {31'd0, conv_start}, 32'd0);
        repeat (2) @(negedge clk);
        check("R8 still waiting", {27'd0, busy, addr}, 32'h10);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        check("R8 advance after done", {28'd0, addr}, 32'd1);
        check("R8 strobe on no-wait cmd", {31'd0, conv_start}, 32'd1);
        @(negedge clk);
        check("R2 done after conversion", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_math();
        clear_mem();
        tmrs = {8'd0, 8'd0, 8'd0, 8'd2};
        mem[0] = mk(4'd5, 0, 0, 0, 0, 1, 1, 0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[1] = mk(4'd0, 0, 0, 0, 0, 1, 0, 1, 2'd0, 2'd0, 2'd0, 2'd0);
        fire();
        check("R9 request first cycle", {30'd0, math_req, math_sel}, 32'd3);
        @(negedge clk);
        check("R9 request not repeated", {31'd0, math_req}, 32'd0);
        while (busy && addr == 4'd0) @(negedge clk);
        check("R9 second command selects first", {30'd0, math_req, math_sel}, 32'd2);
    endtask

    task automatic t_retrigger();
        clear_mem();
        tmrs = {8'd0, 8'd0, 8'd0, 8'd2};
        mem[0] = mk(4'd5, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[1] = mk(4'd5, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[2] = mk(4'd0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 2'd0, 2'd0, 2'd0);
        fire();
        while (busy && addr != 4'd1) @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        check("R3 mid-run trigger keeps address", {27'd0, busy, addr}, 32'h11);
        while (busy && addr != 4'd2) @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        check("R3 trigger in last cycle ignored", {31'd0, busy}, 32'd0);
        @(negedge clk);
        check("R3 no restart", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        clear_mem();
        t_reset();
        t_patterns();
        t_list_timers();
        t_samp_time();
        t_conversion();
        t_math();
        t_retrigger();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule